// File: doc/BRIEF.md
# Either-Edge Wake and Interrupt Controller

This block watches six general-purpose input pins and raises two active-low interrupt requests, one toward power management (PME) and one toward system management (SMI), whenever a watched pin changes level in either direction. Each pin has its own status bits for both destinations, and a third aggregate status register collects the edge events of all pins in one place. Software sees every setting and status through a small register bus with an address, write data, a write strobe and combinational read data.

Each pin is brought into the clock domain by a two-flop synchronizer. An edge is any cycle in which the synchronized level differs from the level one cycle earlier. Edges are recorded in the status bits whatever the enable and mode settings are. A request is only driven when the pin is in either-edge mode, its enable for that destination is set and its status bit is set. Status bits stay set until software writes a 1 to them. A polarity bit per pin inverts only the level that software reads back.

Top module: `edge_wake_ctrl`

## Requirements
- R1: After reset every mode, polarity, enable and status bit reads 0, and both `pme_n` and `smi_n` are 1. A pin held high through reset records no edge after reset is released.
- R2: A level change presented on a pin before clock edge k sets its status bits at clock edge k+2. The status bits still read 0 after edge k+1.
- R3: A low-to-high change and a high-to-low change each set the pin's bit in the PME status, SMI status and aggregate status registers.
- R4: Status bits are set by an edge even when the pin's mode bit and enable bits are 0.
- R5: In the three status registers, writing 1 to a bit clears it and writing 0 leaves it unchanged. A clear in one status register does not change the other two.
- R6: If an edge on a pin and a write-1 clear of that pin's status bit fall on the same clock edge, the bit stays set.
- R7: `pme_n` is 0 exactly when some pin has its mode, PME enable and PME status bits all at 1. `smi_n` follows the same rule with the SMI enable and SMI status bits.
- R8: Reading the data register returns, for each pin, the synchronized pin level XOR its polarity bit. Polarity has no effect on edge detection.
- R9: Register map, with bit i standing for pin i: 0 mode (1 = either-edge), 1 polarity, 2 data (read-only), 3 PME enable, 4 SMI enable, 5 PME status, 6 SMI status, 7 aggregate status. Registers 0, 1, 3 and 4 read back the value last written.
- R10: Once raised, a request stays asserted, with no further pin activity, until software clears the status bit that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Pin levels, asynchronous to clk |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NUM_PINS | Write data, one bit per pin |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rdata | output | NUM_PINS | Combinational read data for bus_addr |
| pme_n | output | 1 | Active-low power-management request |
| smi_n | output | 1 | Active-low system-management request |

## Verification
The bench builds the block with the default NUM_PINS of 6. At that size it can step through every pin under all eight combinations of mode, PME enable and SMI enable. Toggling the pin in each step exercises rising and falling edges for every combination. Six pins also make all 64 polarity patterns cheap to sweep against the data register, and the same-cycle set-versus-clear collision can be tried on every pin.

// File: rtl/ew_pkg.sv
// Shared register addresses for the either-edge wake controller.
// Assumes a 3-bit register address; every code in the space is used.
package ew_pkg;
    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned REG_MODE    = 0;
    localparam int unsigned REG_POL     = 1;
    localparam int unsigned REG_DATA    = 2;
    localparam int unsigned REG_PME_EN  = 3;
    localparam int unsigned REG_SMI_EN  = 4;
    localparam int unsigned REG_PME_STS = 5;
    localparam int unsigned REG_SMI_STS = 6;
    localparam int unsigned REG_AGG_STS = 7;
endpackage

// File: rtl/ew_pin_sync.sv
// Two-flop synchronizer plus a history flop for each pin.
// Outputs the synchronized level and a one-cycle edge pulse for each pin.
// Assumes pins are asynchronous levels. During reset every stage follows the
// pin so that no false edge appears when reset is released.
module ew_pin_sync #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_raw,
    output logic [N-1:0] level,
    output logic [N-1:0] edge_pulse
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pin
            logic meta_q, sync_q, hist_q;

            // Move the pin through two stages and keep the previous synchronized level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= pin_raw[i];
                    sync_q <= pin_raw[i];
                    hist_q <= pin_raw[i];
                end else begin
                    meta_q <= pin_raw[i];
                    sync_q <= meta_q;
                    hist_q <= sync_q;
                end
            end

            assign level[i]      = sync_q;
            assign edge_pulse[i] = sync_q ^ hist_q;
        end
    endgenerate
endmodule

// File: rtl/ew_w1c_bank.sv
// Bank of sticky status bits with write-1-to-clear.
// A set on a bit wins over a clear of the same bit in the same cycle.
module ew_w1c_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    logic [N-1:0] sts_q;

    // Hold each bit until it is cleared, letting a new edge override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_i) | set_i;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/ew_irq_merge.sv
// Combines the qualified status bits of all pins into one active-low request.
// A pin takes part only when its mode bit and enable bit are both set.
module ew_irq_merge #(
    parameter int unsigned N = 6
) (
    input  logic [N-1:0] sts,
    input  logic [N-1:0] en,
    input  logic [N-1:0] mode,
    output logic         irq_n
);
    // NOR of the qualified status bits.
    always_comb irq_n = ~|(sts & en & mode);
endmodule

// File: rtl/edge_wake_ctrl.sv
// Either-edge wake and interrupt controller, top level.
// Holds the mode, polarity and enable registers, decodes the register bus,
// and ties together the synchronizers, the three status banks and the two
// request mergers. Assumes a single clock and a synchronous active-low reset.
module edge_wake_ctrl #(
    parameter int unsigned NUM_PINS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [2:0]            bus_addr,
    input  logic [NUM_PINS-1:0]   bus_wdata,
    input  logic                  bus_wr,
    output logic [NUM_PINS-1:0]   bus_rdata,
    output logic                  pme_n,
    output logic                  smi_n
);
    import ew_pkg::*;

    logic [NUM_PINS-1:0] mode_q, pol_q, pme_en_q, smi_en_q;
    logic [NUM_PINS-1:0] level, edge_vec;
    logic [NUM_PINS-1:0] pme_sts, smi_sts, agg_sts;
    logic [NUM_PINS-1:0] pme_clr, smi_clr, agg_clr;

    // Match the bus address against one register code.
    function automatic logic hit(input logic [2:0] a, input int unsigned code);
        return a == code[2:0];
    endfunction

    ew_pin_sync #(.N(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
        .level(level), .edge_pulse(edge_vec)
    );

    // Update the control registers on a write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            pol_q    <= '0;
            pme_en_q <= '0;
            smi_en_q <= '0;
        end else if (bus_wr) begin
            if (hit(bus_addr, REG_MODE))   mode_q   <= bus_wdata;
            if (hit(bus_addr, REG_POL))    pol_q    <= bus_wdata;
            if (hit(bus_addr, REG_PME_EN)) pme_en_q <= bus_wdata;
            if (hit(bus_addr, REG_SMI_EN)) smi_en_q <= bus_wdata;
        end
    end

    // Turn a write to a status address into a clear mask for that bank.
    always_comb begin
        pme_clr = (bus_wr && hit(bus_addr, REG_PME_STS)) ? bus_wdata : '0;
        smi_clr = (bus_wr && hit(bus_addr, REG_SMI_STS)) ? bus_wdata : '0;
        agg_clr = (bus_wr && hit(bus_addr, REG_AGG_STS)) ? bus_wdata : '0;
    end

    ew_w1c_bank #(.N(NUM_PINS)) u_pme_sts (
        .clk(clk), .rst_n(rst_n), .set_i(edge_vec), .clr_i(pme_clr), .sts_o(pme_sts)
    );
    ew_w1c_bank #(.N(NUM_PINS)) u_smi_sts (
        .clk(clk), .rst_n(rst_n), .set_i(edge_vec), .clr_i(smi_clr), .sts_o(smi_sts)
    );
    ew_w1c_bank #(.N(NUM_PINS)) u_agg_sts (
        .clk(clk), .rst_n(rst_n), .set_i(edge_vec), .clr_i(agg_clr), .sts_o(agg_sts)
    );

    ew_irq_merge #(.N(NUM_PINS)) u_pme_irq (
        .sts(pme_sts), .en(pme_en_q), .mode(mode_q), .irq_n(pme_n)
    );
    ew_irq_merge #(.N(NUM_PINS)) u_smi_irq (
        .sts(smi_sts), .en(smi_en_q), .mode(mode_q), .irq_n(smi_n)
    );

    // Select the read data for the addressed register.
    always_comb begin
        case (bus_addr)
            3'(REG_MODE):    bus_rdata = mode_q;
            3'(REG_POL):     bus_rdata = pol_q;
            3'(REG_DATA):    bus_rdata = level ^ pol_q;
            3'(REG_PME_EN):  bus_rdata = pme_en_q;
            3'(REG_SMI_EN):  bus_rdata = smi_en_q;
            3'(REG_PME_STS): bus_rdata = pme_sts;
            3'(REG_SMI_STS): bus_rdata = smi_sts;
            default:         bus_rdata = agg_sts;
        endcase
    end
endmodule

// Property checker for the controller, attached through bind below.
module ew_chk #(
    parameter int unsigned N = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] edge_vec,
    input logic [N-1:0] pme_sts,
    input logic [N-1:0] smi_sts,
    input logic [N-1:0] agg_sts,
    input logic [N-1:0] mode_q,
    input logic [N-1:0] pme_en_q,
    input logic         bus_wr,
    input logic [2:0]   bus_addr,
    input logic         pme_n,
    input logic         smi_n
);
    // R6
    edge_sets_pme_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |=> ((pme_sts & $past(edge_vec)) == $past(edge_vec)));
    // R3
    edge_sets_agg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |=> ((agg_sts & $past(edge_vec)) == $past(edge_vec)));
    // R2
    no_set_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((smi_sts & ~$past(smi_sts) & ~$past(edge_vec)) == '0));
    // R5
    pme_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 3'd5) |=> ((pme_sts & $past(pme_sts)) == $past(pme_sts)));
    // R7
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0) |-> (pme_n && smi_n));
    // R7
    pme_en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_en_q == '0) |-> pme_n);
endmodule

bind edge_wake_ctrl ew_chk #(.N(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .edge_vec(edge_vec), .pme_sts(pme_sts),
    .smi_sts(smi_sts), .agg_sts(agg_sts), .mode_q(mode_q), .pme_en_q(pme_en_q),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .pme_n(pme_n), .smi_n(smi_n)
);

// File: tb/sim_edge_wake_ctrl.sv
// Bench for the either-edge wake controller: sweeps every pin under every
// mode and enable combination, every polarity pattern, and set/clear collisions.
module sim_edge_wake_ctrl;
    localparam int N = 6;
    localparam logic [2:0] A_MODE = 3'd0, A_POL = 3'd1, A_DATA = 3'd2, A_PEN = 3'd3,
                           A_SEN = 3'd4, A_PSTS = 3'd5, A_SSTS = 3'd6, A_ASTS = 3'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_in = 6'b101010;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic [N-1:0] bus_rdata;
    logic         pme_n, smi_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    edge_wake_ctrl #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .pme_n(pme_n), .smi_n(smi_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [N-1:0] v;
        @(negedge clk);
        wait_n(4);
        rst_n = 1'b1;
        wait_n(5);
        // R1: reset state, pin high bits held through reset record nothing
        for (int a = 0; a < 8; a++) begin
            if (a == 2) continue;
            rd(3'(a), v);
            chk("R1 reg after reset", int'(v), 0);
        end
        chk("R1 pme_n after reset", int'(pme_n), 1);
        chk("R1 smi_n after reset", int'(smi_n), 1);

        // Sweep every pin under all mode / PME enable / SMI enable combinations
        for (int p = 0; p < N; p++) begin
            for (int c = 0; c < 8; c++) begin
                logic m, pe, se;
                logic [N-1:0] bit_p;
                m = c[0]; pe = c[1]; se = c[2];
                bit_p = N'(1) << p;
                wr(A_MODE, m  ? bit_p : '0);
                wr(A_PEN,  pe ? bit_p : '0);
                wr(A_SEN,  se ? bit_p : '0);
                pin_in[p] = ~pin_in[p];
                wait_n(2);
                rd(A_PSTS, v);
                chk("R2 status clear before edge k+2", int'(v), 0);
                wait_n(1);
                rd(A_PSTS, v);
                chk("R3 R4 PME status set", int'(v), int'(bit_p));
                rd(A_SSTS, v);
                chk("R3 R4 SMI status set", int'(v), int'(bit_p));
                rd(A_ASTS, v);
                chk("R3 aggregate status set", int'(v), int'(bit_p));
                chk("R7 pme_n", int'(pme_n), int'(!(m && pe)));
                chk("R7 smi_n", int'(smi_n), int'(!(m && se)));
                wait_n(4);
                chk("R10 pme_n held", int'(pme_n), int'(!(m && pe)));
                chk("R10 smi_n held", int'(smi_n), int'(!(m && se)));
                wr(A_PSTS, ~bit_p);
                rd(A_PSTS, v);
                chk("R5 write 0 keeps PME status", int'(v), int'(bit_p));
                wr(A_PSTS, bit_p);
                rd(A_PSTS, v);
                chk("R5 write 1 clears PME status", int'(v), 0);
                rd(A_SSTS, v);
                chk("R5 SMI status untouched", int'(v), int'(bit_p));
                rd(A_ASTS, v);
                chk("R5 aggregate status untouched", int'(v), int'(bit_p));
                chk("R7 pme_n after clear", int'(pme_n), 1);
                chk("R10 smi_n until own clear", int'(smi_n), int'(!(m && se)));
                wr(A_SSTS, bit_p);
                wr(A_ASTS, bit_p);
                rd(A_SSTS, v);
                chk("R5 SMI status cleared", int'(v), 0);
                rd(A_ASTS, v);
                chk("R5 aggregate cleared", int'(v), 0);
                chk("R7 smi_n after clear", int'(smi_n), 1);
            end
        end

        // R9: read back of control registers
        wr(A_MODE, 6'b110100); wr(A_POL, 6'b001011);
        wr(A_PEN, 6'b011001);  wr(A_SEN, 6'b100110);
        rd(A_MODE, v); chk("R9 mode readback", int'(v), 'h34);
        rd(A_POL, v);  chk("R9 polarity readback", int'(v), 'h0b);
        rd(A_PEN, v);  chk("R9 PME enable readback", int'(v), 'h19);
        rd(A_SEN, v);  chk("R9 SMI enable readback", int'(v), 'h26);
        wr(A_MODE, '0); wr(A_PEN, '0); wr(A_SEN, '0);

        // R8: every polarity pattern against the data register
        pin_in = 6'b011010;
        wait_n(3);
        for (int pv = 0; pv < 64; pv++) begin
            wr(A_POL, 6'(pv));
            rd(A_DATA, v);
            chk("R8 data xor polarity", int'(v), int'(6'b011010 ^ 6'(pv)));
        end
        // R8: polarity all ones does not affect edge detection
        wr(A_PSTS, '1); wr(A_SSTS, '1); wr(A_ASTS, '1);
        wr(A_POL, '1);
        pin_in = ~pin_in;
        wait_n(3);
        rd(A_PSTS, v);
        chk("R8 edges with inverted polarity", int'(v), 'h3f);

        // R6: edge and clear on the same clock edge, then clear alone
        for (int p = 0; p < N; p++) begin
            logic [N-1:0] bit_p;
            bit_p = N'(1) << p;
            pin_in[p] = ~pin_in[p];
            wait_n(2);
            bus_addr = A_PSTS; bus_wdata = bit_p; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0;
            rd(A_PSTS, v);
            chk("R6 set wins over clear", int'(v[p]), 1);
            wr(A_PSTS, bit_p);
            rd(A_PSTS, v);
            chk("R6 clear without edge", int'(v[p]), 0);
        end
        report();
    end
endmodule